// File: doc/BRIEF.md
# Codec Power-Up Clock Sequencer

This block is the host-side controller that takes an audio codec from power-on to a running state, with the codec's PLL locked to an external clock. On a start pulse it first holds the codec's active-low power-down line low long enough to reset the part. It then releases the line and issues four register writes in a fixed order through a request/acknowledge write port. The first two writes set the interface format and the PLL mode. The third turns on the common-mode reference. The fourth enables the PLL. The block then waits out the worst-case PLL lock time and raises a ready flag.

The serial control bus that carries the writes sits outside this block. It is seen only as a handshake: `wr_valid_o` is raised with an address and a data byte, and the write is complete when `wr_ack_i` is seen. The lock wait depends on which clock the PLL is locked to. With the bit clock as reference the wait is 2 ms, and with the frame clock it is 160 ms. Both waits are converted to system clock cycles from the clock-frequency parameter.

The states, in order, are IDLE, RST_LOW, WRITE, GAP, LOCK and READY. The transitions are:
- IDLE→RST_LOW on start.
- RST_LOW→WRITE when the reset interval has elapsed.
- WRITE→GAP on acknowledge of a write that is not the last.
- GAP→WRITE after one cycle.
- WRITE→LOCK on acknowledge of the last write.
- LOCK→READY when the lock interval has elapsed.
- READY→RST_LOW on start.
- Any state→IDLE on reset.

Top module: `codec_pwrup_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pdn_n_o`, `wr_valid_o`, `busy_o` and `ready_o` are all 0.
- R2: After an accepted start, `pdn_n_o` is held at 0 for exactly ceil(RST_LOW_NS × f_clk) + 1 cycles, and is then driven to 1. At 200 MHz and 150 ns this is 31 cycles.
- R3: The writes are issued only while `pdn_n_o` is 1. They come in this order, written as (address, data): (0x03, 0x02), then (0x01, 0x83), then (0x00, 0x01), then (0x02, 0x01).
- R4: `wr_valid_o` stays at 1 with a stable address and data until `wr_ack_i` is sampled high. In the cycle after each acknowledge, `wr_valid_o` is 0, and each acknowledge completes exactly one write.
- R5: The lock wait starts in the cycle after the last acknowledge and lasts LOCK_US × f_clk / 10^6 cycles. The value of `ref_sel_i` sampled with the accepted start selects the wait: 0 selects the bit-clock time (LOCK_BCLK_US) and 1 selects the frame-clock time (LOCK_FCLK_US). Later changes to `ref_sel_i` have no effect.
- R6: `ready_o` rises when the lock wait ends. It stays high, with `pdn_n_o` also high, until the next start or reset.
- R7: `busy_o` is high from the cycle after an accepted start until `ready_o` rises. `busy_o` and `ready_o` are never both high.
- R8: A start received while `busy_o` is high is ignored. `pdn_n_o` stays high and the lock wait length does not change.
- R9: A `wr_ack_i` pulse received while no write is pending has no effect. The lock wait length does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Pulse that launches the sequence |
| ref_sel_i | input | 1 | PLL reference choice: 0 = bit clock, 1 = frame clock |
| wr_ack_i | input | 1 | Write acknowledge from the control bus |
| pdn_n_o | output | 1 | Active-low power-down line to the codec |
| wr_valid_o | output | 1 | Write request pending |
| wr_addr_o | output | 8 | Register address of the pending write |
| wr_data_o | output | 8 | Register data of the pending write |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | PLL lock time has elapsed and normal operation may begin |

## Verification
The assertions assume that `wr_ack_i` is a single-cycle pulse. They also assume that `start_i` is launched only from IDLE or READY, except in the deliberate busy-start cases. The stimulus keeps to this by raising each acknowledge for exactly one cycle, after a chosen latency of 0 to 3 cycles, and only while a write is pending. Spurious acknowledges and busy-time starts are injected only inside the lock wait, where R8 and R9 say they must be harmless. `ref_sel_i` is flipped right after each start to show that only the value sampled with the start matters.

// File: rtl/codec_seq_pkg.sv
`timescale 1ns/1ps
package codec_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST_LOW,
        S_WRITE,
        S_GAP,
        S_LOCK,
        S_READY
    } seq_state_t;

    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    localparam int NUM_WR = 4;

    // Interface format / sample rate, then PLL mode, then reference on, then PLL on.
    localparam reg_wr_t CFG_CLKFMT  = '{addr: 8'h03, data: 8'h02};
    localparam reg_wr_t CFG_PLLMODE = '{addr: 8'h01, data: 8'h83};
    localparam reg_wr_t CFG_VREF_ON = '{addr: 8'h00, data: 8'h01};
    localparam reg_wr_t CFG_PLL_ON  = '{addr: 8'h02, data: 8'h01};

endpackage

// File: rtl/seq_down_counter.sv
`timescale 1ns/1ps
module seq_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_write_table.sv
`timescale 1ns/1ps
module seq_write_table
    import codec_seq_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic [IDX_W-1:0] idx_i,
    output reg_wr_t          entry_o,
    output logic             last_o
);
    always_comb begin
        unique case (idx_i)
            IDX_W'(0): entry_o = CFG_CLKFMT;
            IDX_W'(1): entry_o = CFG_PLLMODE;
            IDX_W'(2): entry_o = CFG_VREF_ON;
            IDX_W'(3): entry_o = CFG_PLL_ON;
            default:   entry_o = CFG_PLL_ON;
        endcase
    end

    assign last_o = (idx_i == IDX_W'(NUM_WR - 1));
endmodule

// File: rtl/codec_pwrup_seq.sv
`timescale 1ns/1ps
module codec_pwrup_seq
    import codec_seq_pkg::*;
#(
    parameter longint unsigned CLK_FREQ_HZ  = 200_000_000,
    parameter int unsigned     RST_LOW_NS   = 150,
    parameter int unsigned     LOCK_BCLK_US = 2000,
    parameter int unsigned     LOCK_FCLK_US = 160000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       ref_sel_i,
    input  logic       wr_ack_i,
    output logic       pdn_n_o,
    output logic       wr_valid_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       busy_o,
    output logic       ready_o
);
    // Cycle counts derived from the clock frequency.
    localparam longint unsigned RST_CYC =
        (64'(RST_LOW_NS) * CLK_FREQ_HZ + 64'd999_999_999) / 64'd1_000_000_000 + 64'd1;
    localparam longint unsigned LOCK_B_RAW = 64'(LOCK_BCLK_US) * CLK_FREQ_HZ / 64'd1_000_000;
    localparam longint unsigned LOCK_F_RAW = 64'(LOCK_FCLK_US) * CLK_FREQ_HZ / 64'd1_000_000;
    localparam longint unsigned LOCK_B_CYC = (LOCK_B_RAW == 0) ? 64'd1 : LOCK_B_RAW;
    localparam longint unsigned LOCK_F_CYC = (LOCK_F_RAW == 0) ? 64'd1 : LOCK_F_RAW;
    localparam longint unsigned LOCK_MAX   = (LOCK_B_CYC > LOCK_F_CYC) ? LOCK_B_CYC : LOCK_F_CYC;
    localparam longint unsigned MAX_CYC    = (LOCK_MAX > RST_CYC) ? LOCK_MAX : RST_CYC;
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam int IDX_W = (NUM_WR > 1) ? $clog2(NUM_WR) : 1;

    localparam logic [CNT_W-1:0] RST_LOAD    = CNT_W'(RST_CYC - 64'd1);
    localparam logic [CNT_W-1:0] LOCK_B_LOAD = CNT_W'(LOCK_B_CYC - 64'd1);
    localparam logic [CNT_W-1:0] LOCK_F_LOAD = CNT_W'(LOCK_F_CYC - 64'd1);

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             ref_q;
    logic             start_ok;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    reg_wr_t          entry;
    logic             last_wr;

    assign start_ok = start_i && ((state_q == S_IDLE) || (state_q == S_READY));

    // Shared interval timer for the reset pulse and the lock wait.
    seq_down_counter #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (cnt_load),
        .load_val_i (cnt_val),
        .zero_o     (cnt_zero)
    );

    seq_write_table #(.IDX_W(IDX_W)) u_table (
        .idx_i   (idx_q),
        .entry_o (entry),
        .last_o  (last_wr)
    );

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_val  = RST_LOAD;
        unique case (state_q)
            S_IDLE, S_READY: begin
                if (start_i) begin
                    state_d  = S_RST_LOW;
                    cnt_load = 1'b1;
                    cnt_val  = RST_LOAD;
                end
            end
            S_RST_LOW: begin
                if (cnt_zero) state_d = S_WRITE;
            end
            S_WRITE: begin
                if (wr_ack_i) begin
                    if (last_wr) begin
                        state_d  = S_LOCK;
                        cnt_load = 1'b1;
                        cnt_val  = ref_q ? LOCK_F_LOAD : LOCK_B_LOAD;
                    end else begin
                        state_d = S_GAP;
                    end
                end
            end
            S_GAP: begin
                state_d = S_WRITE;
            end
            S_LOCK: begin
                if (cnt_zero) state_d = S_READY;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    // Write index and the reference choice latched with the start.
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            ref_q <= 1'b0;
        end else if (start_ok) begin
            idx_q <= '0;
            ref_q <= ref_sel_i;
        end else if ((state_q == S_WRITE) && wr_ack_i && !last_wr) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    // Moore outputs.
    always_comb begin
        pdn_n_o    = 1'b0;
        wr_valid_o = 1'b0;
        busy_o     = 1'b0;
        ready_o    = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_RST_LOW: busy_o = 1'b1;
            S_WRITE: begin
                pdn_n_o    = 1'b1;
                wr_valid_o = 1'b1;
                busy_o     = 1'b1;
            end
            S_GAP, S_LOCK: begin
                pdn_n_o = 1'b1;
                busy_o  = 1'b1;
            end
            S_READY: begin
                pdn_n_o = 1'b1;
                ready_o = 1'b1;
            end
            default: ;
        endcase
    end

    assign wr_addr_o = entry.addr;
    assign wr_data_o = entry.data;
endmodule

// File: rtl/codec_pwrup_seq_chk.sv
`timescale 1ns/1ps
module codec_pwrup_seq_chk #(
    parameter longint unsigned RST_CYC    = 31,
    parameter longint unsigned LOCK_B_CYC = 400000,
    parameter longint unsigned LOCK_F_CYC = 32000000
) (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       ref_sel_i,
    input logic       wr_ack_i,
    input logic       pdn_n_o,
    input logic       wr_valid_o,
    input logic [7:0] wr_addr_o,
    input logic [7:0] wr_data_o,
    input logic       busy_o,
    input logic       ready_o
);
    logic [63:0] low_cnt;
    logic [63:0] since_ack;
    logic        chk_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            since_ack <= '0;
            chk_ref   <= 1'b0;
        end else begin
            if (pdn_n_o)                   low_cnt <= '0;
            else if (low_cnt != '1)        low_cnt <= low_cnt + 64'd1;
            if (wr_valid_o && wr_ack_i)    since_ack <= '0;
            else if (since_ack != '1)      since_ack <= since_ack + 64'd1;
            if (start_i && !busy_o)        chk_ref <= ref_sel_i;
        end
    end

    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pdn_n_o) |-> (low_cnt >= RST_CYC));  // R2

    AST_WRITE_PDN_HIGH: assert property (@(posedge clk) disable iff (rst)
        wr_valid_o |-> pdn_n_o);  // R3

    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && !wr_ack_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));  // R4

    AST_ACK_GAP: assert property (@(posedge clk) disable iff (rst)
        (wr_valid_o && wr_ack_i) |=> !wr_valid_o);  // R4

    AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> (since_ack >= (chk_ref ? LOCK_F_CYC : LOCK_B_CYC)));  // R5

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready_o && !start_i) |=> (ready_o && pdn_n_o));  // R6

    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && ready_o));  // R7

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i && pdn_n_o) |=> pdn_n_o);  // R8
endmodule

bind codec_pwrup_seq codec_pwrup_seq_chk #(
    .RST_CYC    (RST_CYC),
    .LOCK_B_CYC (LOCK_B_CYC),
    .LOCK_F_CYC (LOCK_F_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .ref_sel_i  (ref_sel_i),
    .wr_ack_i   (wr_ack_i),
    .pdn_n_o    (pdn_n_o),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .busy_o     (busy_o),
    .ready_o    (ready_o)
);

// File: tb/tb_codec_pwrup_seq.sv
`timescale 1ns/1ps
module tb_codec_pwrup_seq;
    localparam int CLK_MHZ = 200;
    localparam int RST_NS  = 150;
    localparam int LB_US   = 1;
    localparam int LF_US   = 3;
    localparam int RST_EXP = (RST_NS * CLK_MHZ + 999) / 1000 + 1;
    localparam int LB_EXP  = LB_US * CLK_MHZ;
    localparam int LF_EXP  = LF_US * CLK_MHZ;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ref_sel = 1'b0;
    logic       wr_ack = 1'b0;
    logic       pdn_n, wr_valid, busy, ready;
    logic [7:0] wr_addr, wr_data;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] exp_addr [4] = '{8'h03, 8'h01, 8'h00, 8'h02};
    logic [7:0] exp_data [4] = '{8'h02, 8'h83, 8'h01, 8'h01};

    always #2.5 clk = ~clk;

    codec_pwrup_seq #(
        .CLK_FREQ_HZ  (64'(CLK_MHZ) * 64'd1_000_000),
        .RST_LOW_NS   (RST_NS),
        .LOCK_BCLK_US (LB_US),
        .LOCK_FCLK_US (LF_US)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .ref_sel_i  (ref_sel),
        .wr_ack_i   (wr_ack),
        .pdn_n_o    (pdn_n),
        .wr_valid_o (wr_valid),
        .wr_addr_o  (wr_addr),
        .wr_data_o  (wr_data),
        .busy_o     (busy),
        .ready_o    (ready)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    task automatic idle_outputs(input string req);
        chk(pdn_n == 1'b0, req, pdn_n, 0);
        chk(wr_valid == 1'b0, req, wr_valid, 0);
        chk(busy == 1'b0, req, busy, 0);
        chk(ready == 1'b0, req, ready, 0);
    endtask

    // inj: 0 none, 1 start during lock wait (R8), 2 stray ack during lock wait (R9)
    task automatic run_seq(input logic rsel, input int lat, input int inj);
        int lowc;
        int cnt;
        int lock_exp;
        bit dropped;
        logic [7:0] a0, d0;
        lock_exp = rsel ? LF_EXP : LB_EXP;
        @(negedge clk); start = 1'b1; ref_sel = rsel;
        @(negedge clk); start = 1'b0; ref_sel = ~rsel;
        chk(busy == 1'b1, "R7", busy, 1);
        chk(ready == 1'b0, "R6", ready, 0);
        lowc = 0;
        while (!pdn_n && lowc < 1000) begin
            chk(wr_valid == 1'b0, "R3", wr_valid, 0);
            lowc++;
            @(negedge clk);
        end
        chk(lowc == RST_EXP, "R2", lowc, RST_EXP);
        for (int k = 0; k < 4; k++) begin
            for (int g = 0; g < 100 && !wr_valid; g++) begin
                chk(pdn_n == 1'b1, "R3", pdn_n, 1);
                @(negedge clk);
            end
            chk(wr_valid == 1'b1, "R4", wr_valid, 1);
            a0 = wr_addr;
            d0 = wr_data;
            chk(wr_addr == exp_addr[k], "R3", wr_addr, exp_addr[k]);
            chk(wr_data == exp_data[k], "R3", wr_data, exp_data[k]);
            for (int w = 0; w < lat; w++) begin
                @(negedge clk);
                chk(wr_valid == 1'b1, "R4", wr_valid, 1);
                chk(wr_addr == a0 && wr_data == d0, "R4", {wr_addr, wr_data}, {a0, d0});
            end
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
            chk(wr_valid == 1'b0, "R4", wr_valid, 0);
        end
        chk(busy == 1'b1, "R7", busy, 1);
        cnt = 0;
        dropped = 1'b0;
        while (!ready && cnt < lock_exp + 50) begin
            if (!pdn_n) dropped = 1'b1;
            start  = (inj == 1 && cnt == 5);
            wr_ack = (inj == 2 && cnt == 5);
            cnt++;
            @(negedge clk);
        end
        start  = 1'b0;
        wr_ack = 1'b0;
        case (inj)
            1:       chk(cnt == lock_exp && !dropped, "R8", cnt, lock_exp);
            2:       chk(cnt == lock_exp, "R9", cnt, lock_exp);
            default: chk(cnt == lock_exp, "R5", cnt, lock_exp);
        endcase
        chk(ready == 1'b1, "R6", ready, 1);
        chk(busy == 1'b0, "R7", busy, 0);
        chk(pdn_n == 1'b1, "R6", pdn_n, 1);
        repeat (12) @(negedge clk);
        chk(ready == 1'b1 && pdn_n == 1'b1, "R6", ready, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        idle_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_outputs("R1");

        run_seq(1'b0, 0, 0);
        run_seq(1'b1, 1, 0);
        run_seq(1'b0, 3, 1);
        run_seq(1'b1, 2, 2);
        run_seq(1'b1, 0, 1);
        run_seq(1'b0, 1, 2);

        // Reset in the middle of the write phase.
        @(negedge clk); start = 1'b1; ref_sel = 1'b0;
        @(negedge clk); start = 1'b0;
        for (int g = 0; g < 200 && !wr_valid; g++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        idle_outputs("R1");
        rst = 1'b0;
        @(negedge clk);
        idle_outputs("R1");

        run_seq(1'b0, 2, 0);
        run_seq(1'b1, 3, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule